// File: doc/BRIEF.md
# Flash Security and Lockout Recovery Controller

This block decides, while reset is held, whether the on-chip flash is locked. It compares a stored security word, read from the flash, with a fixed lock code. If they match, the block gates two paths. Memory reads requested over the debug port are refused. A request for external boot made during reset is overridden, so the chip always starts from internal code. The debug port itself stays usable for scan and identification. Only its memory read path is closed.

To leave the locked state, a debug host first loads a 7-bit timing value. It then issues a recovery start. The controller raises a mass-erase request to the flash array and holds it for a fixed number of slow timing ticks. While recovery runs, the loaded value takes the place of the normal flash timing divider. Bit 6 selects a divide-by-8 prescaler. Bits 5:0 give a divider N that divides by N+1. When the erase window ends, the controller reports done. From then until the next reset it treats the flash as erased, which means unlocked. A start issued before any timing value has been loaded is refused and raises an error flag.

Top module: `flash_sec_ctrl`

## Requirements
- R1: While `rst` is high, `secured` takes the value (`sec_word == SEC_CODE`) on every clock. After reset it holds that value, unless it is cleared by R9.
- R2: `dbg_rd_en` equals `dbg_rd_req` when `secured` is low, and is 0 when `secured` is high. It changes in the same cycle as its inputs.
- R3: While `rst` is high, `boot_ext` samples `ext_boot`, except that it is forced to 0 (internal boot) when the security word matches the lock code.
- R4: After reset, `boot_ext` keeps its sampled value whatever `ext_boot` does.
- R5: Outside recovery, `tick` is a one-cycle pulse with a period of (`norm_div[6]` ? 8 : 1) × (`norm_div[5:0]` + 1) clocks. It first appears in the period-th cycle after reset.
- R6: While `mass_erase` is high, the tick period uses the loaded JTAG value in place of `norm_div`, with the same bit meaning. The tick counter restarts at zero on the clock edge that accepts the start.
- R7: A `rec_start` given while no value has been loaded since reset leaves `mass_erase` low. It sets `rec_err`, which stays set until reset.
- R8: An accepted start raises `mass_erase` on the next clock. It stays high for exactly ERASE_TICKS × (recovery period) cycles.
- R9: When `mass_erase` falls, `rec_done` rises and `secured` clears in the same cycle. Both hold until reset, so debug reads become allowed.
- R10: A `jtag_load` or `rec_start` given while `mass_erase` or `rec_done` is high has no effect on the erase length, the tick period or `rec_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; security and boot sampling window |
| sec_word | input | SEC_W | Security word read from flash |
| ext_boot | input | 1 | External boot request pin |
| dbg_rd_req | input | 1 | Memory read request from the debug port |
| norm_div | input | 7 | Normal flash timing divider (bit 6 prescale by 8, bits 5:0 divider) |
| jtag_load | input | 1 | Load strobe for the recovery timing value |
| jtag_div | input | 7 | Recovery timing value from the JTAG data register |
| rec_start | input | 1 | Recovery start command |
| dbg_rd_en | output | 1 | Debug memory read permitted |
| boot_ext | output | 1 | Selected boot mode: 1 external, 0 internal |
| secured | output | 1 | Flash security state |
| tick | output | 1 | Divided timing tick enable |
| mass_erase | output | 1 | Mass-erase request to the flash array |
| rec_done | output | 1 | Recovery complete |
| rec_err | output | 1 | Start was refused because no timing value had been loaded |

## Verification
The bench builds the block with ERASE_TICKS = 3 and the default 16-bit lock code. With these settings several complete erase windows fit into a short run. Each window uses a different recovery divider, including one with the prescaler set, so the length rule of R8 is tested at several periods. The normal divider is also changed to a period of one clock during recovery, which shows that the override of R6 wins. Three resets are applied in turn: locked, unlocked, and locked again. Together they cover the boot override, the refused start and the re-sampling of security after a finished recovery.

// File: rtl/flsec_pkg.sv
package flsec_pkg;

    localparam int DIV_W = 7;
    localparam int PER_W = 10;

    typedef enum logic [1:0] {
        RC_IDLE  = 2'd0,
        RC_ERASE = 2'd1,
        RC_DONE  = 2'd2
    } rc_state_e;

    typedef enum logic {
        BOOT_INT = 1'b0,
        BOOT_EXT = 1'b1
    } boot_e;

    typedef struct packed {
        logic       pre8;
        logic [5:0] div;
    } div_cfg_t;

    function automatic div_cfg_t to_cfg(input logic [DIV_W-1:0] v);
        div_cfg_t c;
        c.pre8 = v[6];
        c.div  = v[5:0];
        return c;
    endfunction

    function automatic logic [PER_W-1:0] period_of(input div_cfg_t c);
        logic [PER_W-1:0] base;
        base = PER_W'(c.div) + PER_W'(1);
        return c.pre8 ? (base << 3) : base;
    endfunction

endpackage

// File: rtl/flsec_sampler.sv
module flsec_sampler
    import flsec_pkg::*;
#(
    parameter int          SEC_W    = 16,
    parameter logic [SEC_W-1:0] SEC_CODE = 16'hC35A
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEC_W-1:0] sec_word,
    input  logic             ext_boot,
    input  logic             wipe,
    output logic             secured,
    output boot_e            boot_sel
);
    logic hit;
    assign hit = (sec_word == SEC_CODE);

    always_ff @(posedge clk) begin
        if (rst) begin
            secured  <= hit;
            boot_sel <= (ext_boot && !hit) ? BOOT_EXT : BOOT_INT;
        end else if (wipe) begin
            secured <= 1'b0;
        end
    end
endmodule

// File: rtl/flsec_tick_gen.sv
module flsec_tick_gen
    import flsec_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             use_ovr,
    input  logic [DIV_W-1:0] norm_val,
    input  logic [DIV_W-1:0] ovr_val,
    output logic             tick
);
    div_cfg_t         cfg;
    logic [PER_W-1:0] per;
    logic [PER_W-1:0] cnt;

    assign cfg  = use_ovr ? to_cfg(ovr_val) : to_cfg(norm_val);
    assign per  = period_of(cfg);
    assign tick = (cnt >= per - PER_W'(1));

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + PER_W'(1);
        end
    end
endmodule

// File: rtl/flsec_recovery.sv
module flsec_recovery
    import flsec_pkg::*;
#(
    parameter int ERASE_TICKS = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rec_start,
    input  logic             ld,
    input  logic [DIV_W-1:0] ld_val,
    input  logic             tick,
    output rc_state_e        state,
    output logic [DIV_W-1:0] ovr_val,
    output logic             restart,
    output logic             wipe,
    output logic             err
);
    localparam int CNT_W = $clog2(ERASE_TICKS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(ERASE_TICKS - 1);

    logic             valid_q;
    logic [CNT_W-1:0] tcnt;

    assign restart = (state == RC_IDLE) && rec_start && valid_q;
    assign wipe    = (state == RC_ERASE) && tick && (tcnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= RC_IDLE;
            valid_q <= 1'b0;
            ovr_val <= '0;
            err     <= 1'b0;
            tcnt    <= '0;
        end else begin
            unique case (state)
                RC_IDLE: begin
                    if (rec_start) begin
                        if (valid_q) begin
                            state <= RC_ERASE;
                            tcnt  <= '0;
                        end else begin
                            err <= 1'b1;
                        end
                    end
                    if (ld) begin
                        valid_q <= 1'b1;
                        ovr_val <= ld_val;
                    end
                end
                RC_ERASE: begin
                    if (tick) begin
                        if (tcnt == LAST) begin
                            state <= RC_DONE;
                        end else begin
                            tcnt <= tcnt + CNT_W'(1);
                        end
                    end
                end
                default: state <= RC_DONE;
            endcase
        end
    end
endmodule

// File: rtl/flash_sec_ctrl.sv
module flash_sec_ctrl
    import flsec_pkg::*;
#(
    parameter int               SEC_W       = 16,
    parameter logic [SEC_W-1:0] SEC_CODE    = 16'hC35A,
    parameter int               ERASE_TICKS = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEC_W-1:0] sec_word,
    input  logic             ext_boot,
    input  logic             dbg_rd_req,
    input  logic [6:0]       norm_div,
    input  logic             jtag_load,
    input  logic [6:0]       jtag_div,
    input  logic             rec_start,
    output logic             dbg_rd_en,
    output logic             boot_ext,
    output logic             secured,
    output logic             tick,
    output logic             mass_erase,
    output logic             rec_done,
    output logic             rec_err
);
    rc_state_e        state;
    boot_e            boot_sel;
    logic [DIV_W-1:0] ovr_val;
    logic             restart;
    logic             wipe;

    flsec_sampler #(.SEC_W(SEC_W), .SEC_CODE(SEC_CODE)) u_samp (
        .clk(clk), .rst(rst), .sec_word(sec_word), .ext_boot(ext_boot),
        .wipe(wipe), .secured(secured), .boot_sel(boot_sel)
    );

    flsec_tick_gen u_tick (
        .clk(clk), .rst(rst), .restart(restart),
        .use_ovr(state == RC_ERASE), .norm_val(norm_div),
        .ovr_val(ovr_val), .tick(tick)
    );

    flsec_recovery #(.ERASE_TICKS(ERASE_TICKS)) u_rec (
        .clk(clk), .rst(rst), .rec_start(rec_start), .ld(jtag_load),
        .ld_val(jtag_div), .tick(tick), .state(state), .ovr_val(ovr_val),
        .restart(restart), .wipe(wipe), .err(rec_err)
    );

    assign dbg_rd_en  = dbg_rd_req && !secured;
    assign boot_ext   = (boot_sel == BOOT_EXT);
    assign mass_erase = (state == RC_ERASE);
    assign rec_done   = (state == RC_DONE);
endmodule

// File: rtl/flsec_chk.sv
module flsec_chk (
    input logic clk,
    input logic rst,
    input logic dbg_rd_en,
    input logic boot_ext,
    input logic secured,
    input logic mass_erase,
    input logic rec_done,
    input logic rec_err
);
    a_r2_no_locked_read: assert property (@(posedge clk) disable iff (rst)
        secured |-> !dbg_rd_en);
    a_r3_locked_boots_internal: assert property (@(posedge clk) disable iff (rst)
        secured |-> !boot_ext);
    a_r4_boot_held: assert property (@(posedge clk) disable iff (rst)
        !mass_erase || mass_erase |=> $stable(boot_ext));
    a_r7_refused_no_erase: assert property (@(posedge clk) disable iff (rst)
        $rose(rec_err) |-> !mass_erase && !rec_done);
    a_r8_erase_then_done: assert property (@(posedge clk) disable iff (rst)
        $fell(mass_erase) |-> rec_done);
    a_r9_done_unlocks: assert property (@(posedge clk) disable iff (rst)
        rec_done |-> !secured && !mass_erase);
    a_r9_done_sticky: assert property (@(posedge clk) disable iff (rst)
        rec_done |=> rec_done);
endmodule

bind flash_sec_ctrl flsec_chk u_chk (
    .clk(clk), .rst(rst), .dbg_rd_en(dbg_rd_en), .boot_ext(boot_ext),
    .secured(secured), .mass_erase(mass_erase), .rec_done(rec_done),
    .rec_err(rec_err)
);

// File: tb/flash_sec_ctrl_tb.sv
`timescale 1ns/1ps
module flash_sec_ctrl_tb;
    localparam int          NT   = 3;
    localparam logic [15:0] CODE = 16'hC35A;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [15:0] sec_word = CODE;
    logic ext_boot = 1'b1, dbg_rd_req = 1'b0, jtag_load = 1'b0, rec_start = 1'b0;
    logic [6:0] norm_div = 7'h03, jtag_div = 7'h00;
    logic dbg_rd_en, boot_ext, secured, tick, mass_erase, rec_done, rec_err;

    always #2 clk = ~clk;

    flash_sec_ctrl #(.SEC_W(16), .SEC_CODE(CODE), .ERASE_TICKS(NT)) u_dut (
        .clk(clk), .rst(rst), .sec_word(sec_word), .ext_boot(ext_boot),
        .dbg_rd_req(dbg_rd_req), .norm_div(norm_div), .jtag_load(jtag_load),
        .jtag_div(jtag_div), .rec_start(rec_start), .dbg_rd_en(dbg_rd_en),
        .boot_ext(boot_ext), .secured(secured), .tick(tick),
        .mass_erase(mass_erase), .rec_done(rec_done), .rec_err(rec_err)
    );

    int n_cmp = 0, n_bad = 0;
    bit run = 0;
    int m_sec, m_bext, m_state, m_valid, m_jdiv, m_err, m_cnt, m_ticks;
    int erase_len = 0;

    function automatic int per_of(int v);
        return (((v >> 6) & 1) ? 8 : 1) * ((v & 63) + 1);
    endfunction

    function automatic int cur_per();
        return per_of(m_state == 1 ? m_jdiv : int'(norm_div));
    endfunction

    // reference model, updated on every rising edge
    always @(posedge clk) begin
        int hit, tk, go;
        run = 1;
        if (rst) begin
            hit = (sec_word == CODE);
            m_sec = hit; m_bext = ext_boot && !hit;
            m_state = 0; m_valid = 0; m_jdiv = 0; m_err = 0; m_cnt = 0; m_ticks = 0;
        end else begin
            tk = (m_cnt >= cur_per() - 1);
            go = (m_state == 0) && rec_start && m_valid;
            case (m_state)
                0: begin
                    if (rec_start) begin
                        if (m_valid) begin m_state = 1; m_ticks = 0; end
                        else m_err = 1;
                    end
                    if (jtag_load) begin m_valid = 1; m_jdiv = jtag_div; end
                end
                1: if (tk) begin
                    if (m_ticks == NT - 1) begin m_state = 2; m_sec = 0; end
                    else m_ticks++;
                end
                default: ;
            endcase
            if (go || tk) m_cnt = 0; else m_cnt++;
        end
    end

    task automatic cmp(string tag, string nm, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, nm, act, exp, $time);
        end
    endtask

    always @(negedge clk) if (run) begin
        cmp("R1", "secured", secured, m_sec);
        cmp("R2", "dbg_rd_en", dbg_rd_en, dbg_rd_req && !m_sec);
        cmp("R3/R4", "boot_ext", boot_ext, m_bext);
        if (!rst) cmp(m_state == 1 ? "R6" : "R5", "tick", tick, m_cnt >= cur_per() - 1);
        cmp("R8/R10", "mass_erase", mass_erase, m_state == 1);
        cmp("R9", "rec_done", rec_done, m_state == 2);
        cmp("R7", "rec_err", rec_err, m_err);
        if (mass_erase) erase_len++;
    end

    task automatic cyc(int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic do_reset(logic [15:0] w, logic eb);
        rst = 1; sec_word = w; ext_boot = eb; cyc(3);
        sec_word = 16'h0; rst = 0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    task automatic check_len(int exp);
        // R8: erase window length in cycles
        cmp("R8", "erase_len", erase_len, exp);
        erase_len = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL R8 watchdog: actual hung expected finished");
        summary();
    end

    initial begin
        // locked reset, external boot requested: R1, R3
        do_reset(CODE, 1'b1);
        for (int i = 0; i < 20; i++) begin
            dbg_rd_req = i[0]; ext_boot = i[1]; cyc(1);   // R2, R4
        end
        dbg_rd_req = 1;
        // R7: start before any load
        rec_start = 1; cyc(1); rec_start = 0; cyc(5);
        // load prescaled value: period 16, R6
        jtag_div = 7'h41; jtag_load = 1; cyc(1); jtag_load = 0;
        norm_div = 7'h00; cyc(3);
        rec_start = 1; cyc(1); rec_start = 0;
        // R10: load and start during erase are ignored
        cyc(7); jtag_div = 7'h00; jtag_load = 1; rec_start = 1; cyc(2);
        jtag_load = 0; rec_start = 0;
        cyc(16 * NT + 5);
        check_len(16 * NT);
        rec_start = 1; jtag_load = 1; cyc(2); rec_start = 0; jtag_load = 0; // R10 after done
        cyc(6);
        // unlocked reset: external boot honoured, R5 with prescaled normal divider
        do_reset(16'h1234, 1'b1);
        norm_div = 7'h45; dbg_rd_req = 1;
        for (int i = 0; i < 120; i++) begin ext_boot = i[2]; cyc(1); end
        // locked again after erase: re-sampled, R1
        do_reset(CODE, 1'b0);
        norm_div = 7'h02;
        jtag_div = 7'h02; jtag_load = 1; rec_start = 1; cyc(1); // same-cycle load: refused
        jtag_load = 0; rec_start = 0; cyc(2);
        rec_start = 1; cyc(1); rec_start = 0;
        cyc(3 * NT + 4);
        check_len(3 * NT);
        summary();
    end
endmodule